// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface unit of a small 8-bit processor whose external bus shares its low address byte and its data byte on the same eight pins. When the core raises a request for a memory or I/O read or write, the sequencer runs a bus cycle of four clocks: first, second, third and fourth phase. In the first phase it puts the low address byte on the shared pins and raises an address-latch strobe so an external latch can capture it. In the later phases the same pins carry write data or are released so that read data can be sampled.

A slow device can stretch any cycle by holding a ready input low. Each low sample taken at the end of the third phase, or at the end of a wait phase, adds one more wait clock before the fourth phase. The block also drives the direction and enable controls of an external data transceiver. It decodes the read strobe, the write strobe and the memory/I-O select into four separate active-low command strobes: I/O read, I/O write, memory read and memory write.

The core side uses a simple handshake. A request is taken only while the sequencer is idle. A one-clock done pulse, together with the captured read data, follows the fourth phase. The reset is synchronous and active-low.

Top module: `mux_bus_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, the sequencer returns to idle on that edge. In idle: ale is 0, rd_n, wr_n and all four command strobes are 1, ad_oe is 0, ad_o and addr_hi are 0, io_m is 0, dtr is 1, den_n is 1, req_ready is 1, done is 0. Reset also clears rdata to 0.
- R2: req_ready is 1 only in idle. A request (req_valid=1) is taken at an edge where req_ready is 1, and the first phase follows on the next clock. Request inputs that change while a cycle runs have no effect on that cycle's pin outputs.
- R3: ale is 1 in the first phase only. In that phase ad_oe is 1 and ad_o carries req_addr[7:0].
- R4: For a read, rd_n is 0 in the second phase, the third phase and every wait phase. For a write, wr_n is 0 in those same phases. Both strobes are 1 in the first and fourth phases. They are never low together.
- R5: ready_in is sampled only at the end of the third phase and at the end of each wait phase. A 0 sample adds one wait phase; a 1 sample moves the cycle to the fourth phase. A cycle with n low samples lasts 4+n clocks. The value of ready_in during the first and second phases has no effect.
- R6: On a write, ad_oe is 1 and ad_o carries req_wdata from the second phase through the fourth. On a read, ad_oe is 0 from the second phase onward.
- R7: From the first phase to the fourth, addr_hi carries req_addr[19:8] and io_m carries the request's I/O flag (1 = I/O, 0 = memory). Both stay unchanged across the cycle.
- R8: dtr is 0 from the first phase to the fourth of a read, and 1 otherwise (1 = toward the system side). den_n is 0 from the second phase through the fourth, and 1 elsewhere.
- R9: ior_n, iow_n, memr_n and memw_n are active-low. Each is 0 exactly when the matching strobe (rd_n or wr_n) is 0 with the matching io_m value. At most one of them is 0 at any time.
- R10: done is 1 for exactly one clock, the clock after the fourth phase. After a read, rdata then holds the ad_i value sampled at the end of the fourth phase. A write leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer idle, a request is taken |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Data captured by the last read |
| ready_in | input | 1 | Bus ready; low inserts wait phases |
| ad_i | input | 8 | Shared pins, input side |
| ad_o | output | 8 | Shared pins, output side (address low byte or write data) |
| ad_oe | output | 1 | Output enable for the shared pins |
| addr_hi | output | 12 | Address bits 19..8 |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active-low |
| wr_n | output | 1 | Write strobe, active-low |
| io_m | output | 1 | 1 = I/O access, 0 = memory access |
| dtr | output | 1 | Transceiver direction, 0 = toward the processor |
| den_n | output | 1 | Transceiver enable, active-low |
| ior_n | output | 1 | I/O read command, active-low |
| iow_n | output | 1 | I/O write command, active-low |
| memr_n | output | 1 | Memory read command, active-low |
| memw_n | output | 1 | Memory write command, active-low |

## Verification
The assertions take for granted that reset is held low for at least one edge before any request. They also assume that ready_in is the only input able to stretch a cycle, so a strobe low without ale always belongs to a cycle that has already latched its address. The stimulus keeps to this. Reset is held for several clocks at the start. Ready is driven low on purpose during the first and second phases, where it must be ignored. Request fields are changed while a cycle runs, so the no-effect rule of R2 and the stability rule of R7 are both exercised. One reset is also applied mid-cycle.

// File: rtl/bus_seq_pkg.sv
// Package: shared phase encoding and request-kind type for the bus cycle sequencer.
// Assumes a single clock domain; phase values are internal and not decoded by neighbours.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef struct packed {
        logic is_write;
        logic is_io;
    } kind_t;

endpackage

// File: rtl/bus_phase_fsm.sv
// Module: bus_phase_fsm
// Steps the bus cycle through its phases. Leaves idle on start. Samples ready_in
// only at the end of the third phase and of every wait phase.
// Assumes start is asserted only while the phase is idle.
module bus_phase_fsm
    import bus_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   ready_in,
    output phase_e phase
);

    phase_e phase_nx;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE: if (start) phase_nx = PH_T1;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   phase_nx = ready_in ? PH_T4 : PH_TW;
            PH_TW:   phase_nx = ready_in ? PH_T4 : PH_TW;
            PH_T4:   phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

endmodule

// File: rtl/bus_req_hold.sv
// Module: bus_req_hold
// Holds the accepted request for the length of its bus cycle. Captures read
// data at the end of the fourth phase and produces the one-clock done pulse.
// Assumes start coincides with the idle phase.
module bus_req_hold
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] ad_i,
    output kind_t             kind,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind.is_write <= req_write;
            kind.is_io    <= req_io;
            addr_q        <= req_addr;
            wdata_q       <= req_wdata;
        end
    end

    // Completion pulse and read-data capture at the end of the fourth phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= (phase == PH_T4);
            if (phase == PH_T4 && !kind.is_write) rdata <= ad_i;
        end
    end

endmodule

// File: rtl/bus_pin_drive.sv
// Module: bus_pin_drive
// Decodes phase and held request into shared-pin drive, latch strobe, read and
// write strobes, space select and transceiver controls. Purely combinational.
// Assumes the held request is stable whenever phase is not idle.
module bus_pin_drive
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  phase_e            phase,
    input  kind_t             kind,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              dtr,
    output logic              den_n
);

    logic active;
    logic strobe_ph;
    logic data_ph;

    // Phase groupings used by all pin equations.
    always_comb begin
        active    = (phase != PH_IDLE);
        strobe_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
        data_ph   = strobe_ph || (phase == PH_T4);
    end

    // Shared-pin multiplexing: address byte first, then write data or release.
    always_comb begin
        ad_o  = '0;
        ad_oe = 1'b0;
        if (phase == PH_T1) begin
            ad_o  = addr_q[DATA_W-1:0];
            ad_oe = 1'b1;
        end else if (data_ph && kind.is_write) begin
            ad_o  = wdata_q;
            ad_oe = 1'b1;
        end
    end

    // Control strobes, upper address and transceiver controls.
    always_comb begin
        ale     = (phase == PH_T1);
        rd_n    = !(strobe_ph && !kind.is_write);
        wr_n    = !(strobe_ph && kind.is_write);
        addr_hi = active ? addr_q[ADDR_W-1:DATA_W] : '0;
        io_m    = active && kind.is_io;
        dtr     = !(active && !kind.is_write);
        den_n   = !data_ph;
    end

endmodule

// File: rtl/bus_cmd_decode.sv
// Module: bus_cmd_decode
// Splits the read/write strobes by address space into four active-low commands.
// Assumes rd_n and wr_n are never low together.
module bus_cmd_decode (
    input  logic rd_n,
    input  logic wr_n,
    input  logic io_m,
    output logic ior_n,
    output logic iow_n,
    output logic memr_n,
    output logic memw_n
);

    // Command decode from strobe and space select.
    always_comb begin
        ior_n  = !(!rd_n &&  io_m);
        iow_n  = !(!wr_n &&  io_m);
        memr_n = !(!rd_n && !io_m);
        memw_n = !(!wr_n && !io_m);
    end

endmodule

// File: rtl/mux_bus_sequencer.sv
// Module: mux_bus_sequencer (top)
// Bus interface unit for a multiplexed address/data bus: four-phase cycles,
// wait-phase stretching, transceiver control and command decode.
// Assumes one clock domain and a synchronous active-low reset.
module mux_bus_sequencer
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              ready_in,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    output logic [HI_W-1:0]   addr_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              dtr,
    output logic              den_n,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n
);

    phase_e            phase;
    kind_t             kind;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              start;

    // Handshake: a request is taken only in idle.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        start     = req_valid && req_ready;
    end

    bus_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ready_in (ready_in),
        .phase    (phase)
    );

    bus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_write (req_write),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (phase),
        .ad_i      (ad_i),
        .kind      (kind),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .done      (done),
        .rdata     (rdata)
    );

    bus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase   (phase),
        .kind    (kind),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe),
        .addr_hi (addr_hi),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .io_m    (io_m),
        .dtr     (dtr),
        .den_n   (den_n)
    );

    bus_cmd_decode u_cmd (
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .io_m   (io_m),
        .ior_n  (ior_n),
        .iow_n  (iow_n),
        .memr_n (memr_n),
        .memw_n (memw_n)
    );

endmodule

// File: rtl/bus_seq_checker.sv
// Module: bus_seq_checker
// Port-level temporal checks for mux_bus_sequencer, attached by bind.
// Assumes reset is applied before the first request.
module bus_seq_checker #(
    parameter int HI_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            done,
    input logic            ad_oe,
    input logic [HI_W-1:0] addr_hi,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            io_m,
    input logic            dtr,
    input logic            den_n,
    input logic            ior_n,
    input logic            iow_n,
    input logic            memr_n,
    input logic            memw_n
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !ad_oe && rd_n && wr_n && !ale && !done));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (rd_n && wr_n && !ale && den_n));

    assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_drives_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n));

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !ale) |-> ($stable(addr_hi) && $stable(io_m)));

    assert_read_direction_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!dtr && !den_n));

    assert_one_command_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ior_n, ~iow_n, ~memr_n, ~memw_n}) <= 1);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind mux_bus_sequencer bus_seq_checker #(.HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .dtr       (dtr),
    .den_n     (den_n),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .memr_n    (memr_n),
    .memw_n    (memw_n)
);

// File: tb/sim_mux_bus_sequencer.sv
// Bench: behavioural per-clock reference model compared with every output.
module sim_mux_bus_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready_in = 1'b1;
    logic [7:0]  ad_i = '0;
    logic        req_ready, done, ad_oe, ale, rd_n, wr_n, io_m, dtr, den_n;
    logic        ior_n, iow_n, memr_n, memw_n;
    logic [7:0]  rdata, ad_o;
    logic [11:0] addr_hi;

    int checks = 0, fails = 0;
    int m_ph = 0;            // 0 idle, 1..3 phases, 5 wait, 4 fourth phase
    bit m_w, m_io, m_done;
    bit [19:0] m_a;
    bit [7:0]  m_wd, m_rd;
    bit checking = 0;
    int wait_left = 0;
    int den_cnt = 0;

    always #4 clk = ~clk;    // 125 MHz

    mux_bus_sequencer u0 (.*);

    // Reference model: advances with the bench's own view of the cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_done <= 0; m_rd <= '0;
        end else begin
            m_done <= 0;
            case (m_ph)
                0: if (req_valid) begin
                       m_ph <= 1; m_w <= req_write; m_io <= req_io;
                       m_a <= req_addr; m_wd <= req_wdata;
                   end
                1: m_ph <= 2;
                2: m_ph <= 3;
                3, 5: m_ph <= ready_in ? 4 : 5;
                4: begin m_ph <= 0; m_done <= 1; if (!m_w) m_rd <= ad_i; end
                default: m_ph <= 0;
            endcase
        end
    end

    // Ready driver: low during first/second phase (must be ignored), pattern later.
    always @(posedge clk) begin
        #2;
        if (m_ph == 1 || m_ph == 2) ready_in = 1'b0;
        else if (m_ph == 3 || m_ph == 5) begin
            ready_in = (wait_left == 0);
            if (wait_left > 0) wait_left--;
        end else ready_in = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            bit act, strb, dph, rd_e, wr_e;
            act  = (m_ph != 0);
            strb = (m_ph == 2 || m_ph == 3 || m_ph == 5);
            dph  = strb || (m_ph == 4);
            rd_e = strb && !m_w;
            wr_e = strb && m_w;
            if (!den_n) den_cnt++;
            chk(req_ready == !act, "R2 req_ready", req_ready, !act);
            chk(ale == (m_ph == 1), "R3 ale", ale, m_ph == 1);
            chk(ad_oe == ((m_ph == 1) || (dph && m_w)), "R6 ad_oe", ad_oe, (m_ph == 1) || (dph && m_w));
            chk(ad_o == ((m_ph == 1) ? m_a[7:0] : (dph && m_w) ? m_wd : 8'h00), "R3/R6 ad_o",
                ad_o, (m_ph == 1) ? m_a[7:0] : (dph && m_w) ? m_wd : 8'h00);
            chk(rd_n == !rd_e, "R4 rd_n", rd_n, !rd_e);
            chk(wr_n == !wr_e, "R4 wr_n", wr_n, !wr_e);
            chk(addr_hi == (act ? m_a[19:8] : 12'h0), "R7 addr_hi", addr_hi, act ? m_a[19:8] : 12'h0);
            chk(io_m == (act && m_io), "R7 io_m", io_m, act && m_io);
            chk(dtr == !(act && !m_w), "R8 dtr", dtr, !(act && !m_w));
            chk(den_n == !dph, "R8 den_n", den_n, !dph);
            chk(ior_n == !(rd_e && m_io), "R9 ior_n", ior_n, !(rd_e && m_io));
            chk(iow_n == !(wr_e && m_io), "R9 iow_n", iow_n, !(wr_e && m_io));
            chk(memr_n == !(rd_e && !m_io), "R9 memr_n", memr_n, !(rd_e && !m_io));
            chk(memw_n == !(wr_e && !m_io), "R9 memw_n", memw_n, !(wr_e && !m_io));
            chk(done == m_done, "R10 done", done, m_done);
            chk(rdata == m_rd, "R10 rdata", rdata, m_rd);
        end
    end

    // One transfer with a given number of low ready samples; checks its length (R5).
    task automatic xfer(input bit w, input bit io, input bit [19:0] a,
                        input bit [7:0] d, input int waits, input bit [7:0] rv);
        @(posedge clk); #1;
        req_valid = 1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
        ad_i = rv; wait_left = waits; den_cnt = 0;
        @(posedge clk); #1;
        req_valid = 0;
        req_addr = ~a; req_wdata = ~d; req_io = ~io; req_write = ~w;   // R2: ignored mid-cycle
        do @(posedge clk); while (!m_done);
        @(negedge clk);
        chk(den_cnt == 3 + waits, "R5 cycle length", den_cnt, 3 + waits);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 checking = 1;
        @(negedge clk);
        chk(req_ready && !ad_oe && rd_n && wr_n && dtr && den_n && rdata == 0, "R1 reset state",
            {req_ready, ad_oe, rd_n, wr_n}, 4'b1011);
        @(posedge clk); #1 rst_n = 1;
        xfer(0, 0, 20'h12345, 8'h00, 0, 8'hA5);   // memory read
        chk(rdata == 8'hA5, "R10 read data", rdata, 8'hA5);
        xfer(1, 0, 20'hABCDE, 8'h3C, 0, 8'h11);   // memory write
        chk(rdata == 8'hA5, "R10 write keeps rdata", rdata, 8'hA5);
        xfer(0, 1, 20'h003F8, 8'h00, 2, 8'h5A);   // I/O read, two waits
        xfer(1, 1, 20'h00060, 8'hC3, 1, 8'h00);   // I/O write, one wait
        xfer(0, 0, 20'hFFFFF, 8'h00, 5, 8'hFF);   // top address, long stretch
        xfer(1, 0, 20'h00000, 8'h00, 0, 8'h77);   // zero address, zero data
        // Back-to-back: request held high across completion.
        @(posedge clk); #1;
        req_valid = 1; req_write = 0; req_io = 0; req_addr = 20'h2468A; ad_i = 8'h9C; wait_left = 0;
        repeat (3) @(posedge clk);
        #1 req_addr = 20'h13579;
        do @(posedge clk); while (!m_done);
        #1 ad_i = 8'h42;
        do @(posedge clk); while (!m_done);
        #1 req_valid = 0;
        @(negedge clk);
        chk(rdata == 8'h42, "R2 second queued read", rdata, 8'h42);
        // Reset in the middle of a write cycle.
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_io = 1; req_addr = 20'h0F0F0; req_wdata = 8'hE1;
        @(posedge clk); #1 req_valid = 0;
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(req_ready && wr_n && !ad_oe && iow_n, "R1 mid-cycle reset", {req_ready, wr_n, ad_oe}, 3'b110);
        @(posedge clk); #1 rst_n = 1;
        xfer(0, 1, 20'h00201, 8'h00, 0, 8'h3D);
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule